// File: doc/BRIEF.md
# Serial Receiver with Per-Character Status FIFO

This block receives asynchronous serial characters on a single input line. It is paced by a 16x oversampling tick supplied from outside. It watches the idle-high line for a falling edge and confirms a start bit by a mid-bit vote. It then collects 5 to 9 data bits, least significant first, and an optional parity bit. It decides the first stop bit and hands the finished character to a small receive queue.

Each queue entry holds the character together with its own error flags: framing, parity and overrun. For 9-bit characters the entry also holds the top data bit. These flags stay with their character, so software reads the flags and ninth bit of the oldest character first. Software then reads the data byte, and that read pulse retires the entry. Clearing the enable empties the queue and returns the receiver to hunting.

Top module: `serial_rx_fifo`

## Requirements
- R1: In the idle state a low sample on `rxd` at an `os_tick` begins a start bit. The start bit is accepted only if the majority of its samples 7, 8 and 9 (of 0 to 15) is low. A high majority abandons the frame, stores nothing and resumes hunting.
- R2: Data bits are received least significant bit first. Each bit value is the majority of that bit period's samples 7, 8 and 9. The number of data bits is `cfg_bits`, with values below 5 treated as 5 and values above 9 treated as 9.
- R3: Bit positions at or above the configured data width read as zero. `data_out` carries data bits 0 to 7. `bit9_out` carries data bit 8, and it is 0 unless 9 data bits are configured.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `pe_out` of that character is 1 when the count of ones in the data plus the parity bit is odd with `cfg_par_odd`=0 (even parity), or even with `cfg_par_odd`=1 (odd parity). `pe_out` is 0 when parity is disabled.
- R5: The character is stored as soon as the first stop bit has been voted at its sample 9. `fe_out` is 1 when that vote is low. The receiver then resumes hunting at once, so a second stop bit is never checked, and a start bit may follow a single stop bit directly.
- R6: `rx_avail` is 1 exactly when the queue holds at least one character. While it is 1, `data_out`, `bit9_out`, `fe_out`, `dor_out` and `pe_out` show the oldest character. While it is 0, these outputs are all 0, and this includes the state after reset.
- R7: A one-cycle `rd_data` pulse while `rx_avail` is 1 removes the oldest character, and the next one becomes visible on the following cycle. Without such a pulse the visible data, ninth bit, framing and parity flags do not change. A pulse while the queue is empty has no effect.
- R8: The queue holds 2 characters. A character that completes while the queue is full and not being read is discarded. `dor_out` of the most recently stored character is then set, and the older character is left unchanged.
- R9: While `rx_en` is 0 the queue is emptied and the receiver stays idle. No character is received during that time, and none appears after `rx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes and idles |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial input, idle high (synchronised inside) |
| cfg_bits | input | 4 | Data bits per character, clamped to 5..9 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_data | input | 1 | Read strobe for the data word; pops the head entry |
| data_out | output | 8 | Head character, bits 7:0 |
| bit9_out | output | 1 | Head character, data bit 8 |
| fe_out | output | 1 | Head character framing error |
| dor_out | output | 1 | Head character overrun (a later character was lost) |
| pe_out | output | 1 | Head character parity error |
| rx_avail | output | 1 | Queue holds at least one character |

## Verification
Four properties are checked on every cycle:
- every character handed to the queue has zero in its unused upper bit positions;
- a stored character is always flagged as available on the next cycle;
- the visible head fields hold steady until a read;
- a low enable leaves nothing available on the next cycle.

Only the bench scenarios can show the rest. These cover the bit values recovered from the line, parity and framing decisions in each mode, rejection of a short low glitch, and start bits that follow a single stop bit. They also cover the loss of a third character into a full queue with the overrun mark on the right entry, and the order in which characters leave the queue.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int MAX_BITS = 9;

    typedef enum logic [2:0] {
        S_HUNT  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_PAR   = 3'd3,
        S_STOP  = 3'd4
    } rx_state_e;

    // character as produced by the frame sampler
    typedef struct packed {
        logic [MAX_BITS-1:0] word;
        logic                fe;
        logic                pe;
    } rx_char_t;

    // character as held in the receive queue
    typedef struct packed {
        logic [7:0] data;
        logic       bit9;
        logic       fe;
        logic       dor;
        logic       pe;
    } fifo_ent_t;

endpackage

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      tick,
    input  logic      rxd,
    input  logic [3:0] cfg_bits,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      push_valid,
    output rx_char_t  push_char
);

    localparam int CW  = $clog2(OVERSAMPLE);
    localparam int MID = OVERSAMPLE / 2;
    localparam logic [CW-1:0] SMP_LO  = CW'(MID - 1);
    localparam logic [CW-1:0] SMP_HI  = CW'(MID + 1);
    localparam logic [CW-1:0] SMP_END = CW'(OVERSAMPLE - 1);

    typedef struct packed {
        rx_state_e           st;
        logic [CW-1:0]       cnt;
        logic [2:0]          vote;
        logic [3:0]          idx;
        logic [MAX_BITS-1:0] word;
        logic                par_bit;
    } smp_state_t;

    smp_state_t q, d;
    logic [3:0] nbits;
    logic       maj_now;
    logic       maj_all;

    always_comb begin
        nbits   = (cfg_bits < 4'd5) ? 4'd5 : ((cfg_bits > 4'd9) ? 4'd9 : cfg_bits);
        // vote of the two stored samples and the current one
        maj_now = (q.vote[1] & q.vote[0]) | (q.vote[1] & rxd) | (q.vote[0] & rxd);
        // vote of the three stored samples
        maj_all = (q.vote[2] & q.vote[1]) | (q.vote[2] & q.vote[0]) | (q.vote[1] & q.vote[0]);

        d          = q;
        push_valid = 1'b0;
        push_char  = '0;

        if (!enable) begin
            d = '0;
        end else if (tick) begin
            if (q.st == S_HUNT) begin
                if (!rxd) begin
                    d.st   = S_START;
                    d.cnt  = CW'(1);
                    d.word = '0;
                end
            end else begin
                d.cnt = (q.cnt == SMP_END) ? '0 : q.cnt + 1'b1;
                if (q.cnt >= SMP_LO && q.cnt <= SMP_HI) begin
                    d.vote = {q.vote[1:0], rxd};
                end
                if (q.st == S_STOP && q.cnt == SMP_HI) begin
                    push_valid     = 1'b1;
                    push_char.word = q.word;
                    push_char.fe   = ~maj_now;
                    push_char.pe   = par_en & (^q.word ^ q.par_bit ^ par_odd);
                    d.st           = S_HUNT;
                    d.cnt          = '0;
                end else if (q.cnt == SMP_END) begin
                    case (q.st)
                        S_START: begin
                            d.st  = maj_all ? S_HUNT : S_DATA;
                            d.idx = '0;
                        end
                        S_DATA: begin
                            d.word[q.idx] = maj_all;
                            if (q.idx == nbits - 4'd1) begin
                                d.st = par_en ? S_PAR : S_STOP;
                            end else begin
                                d.idx = q.idx + 4'd1;
                            end
                        end
                        S_PAR: begin
                            d.par_bit = maj_all;
                            d.st      = S_STOP;
                        end
                        default: d.st = S_HUNT;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      push,
    input  rx_char_t  push_char,
    input  logic      pop,
    output logic      avail,
    output fifo_ent_t head
);

    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0]   LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

    typedef struct packed {
        fifo_ent_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wr;
        logic [PW-1:0]         rd;
        logic [CNTW-1:0]       cnt;
    } fifo_state_t;

    fifo_state_t q, d;
    logic          do_pop;
    logic          accept;
    logic [PW-1:0] newest;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_pop = pop && (q.cnt != '0);
        accept = push && ((q.cnt != FULL_CNT) || do_pop);
        newest = (q.wr == '0) ? LAST_IDX : q.wr - 1'b1;
        d      = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_pop) d.rd = ptr_inc(q.rd);
            if (accept) begin
                d.mem[q.wr] = {push_char.word[7:0], push_char.word[8],
                               push_char.fe, 1'b0, push_char.pe};
                d.wr = ptr_inc(q.wr);
            end else if (push) begin
                d.mem[newest].dor = 1'b1;
            end
            d.cnt = q.cnt + CNTW'(accept) - CNTW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign avail = (q.cnt != '0);
    assign head  = avail ? q.mem[q.rd] : '0;

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int FIFO_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [3:0] cfg_bits,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rd_data,
    output logic [7:0] data_out,
    output logic       bit9_out,
    output logic       fe_out,
    output logic       dor_out,
    output logic       pe_out,
    output logic       rx_avail
);

    logic [1:0] sync_d, sync_q;
    logic       smp_push;
    rx_char_t   smp_char;
    logic [8:0] smp_word;
    fifo_ent_t  head;

    always_comb sync_d = {sync_q[0], rxd};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= sync_d;
    end

    rx_frame_sampler #(.OVERSAMPLE(OVERSAMPLE)) i_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_en),
        .tick       (os_tick),
        .rxd        (sync_q[1]),
        .cfg_bits   (cfg_bits),
        .par_en     (cfg_par_en),
        .par_odd    (cfg_par_odd),
        .push_valid (smp_push),
        .push_char  (smp_char)
    );

    rx_char_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (~rx_en),
        .push      (smp_push),
        .push_char (smp_char),
        .pop       (rd_data),
        .avail     (rx_avail),
        .head      (head)
    );

    assign smp_word = smp_char.word;
    assign data_out = head.data;
    assign bit9_out = head.bit9;
    assign fe_out   = head.fe;
    assign dor_out  = head.dor;
    assign pe_out   = head.pe;

endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rd_data,
    input logic [3:0] cfg_bits,
    input logic       rx_avail,
    input logic [7:0] data_out,
    input logic       bit9_out,
    input logic       fe_out,
    input logic       pe_out,
    input logic       push_valid,
    input logic [8:0] push_word
);

    logic [3:0] width_eff;
    always_comb width_eff = (cfg_bits < 4'd5) ? 4'd5 : ((cfg_bits > 4'd9) ? 4'd9 : cfg_bits);

    // R3: no bit at or above the configured width reaches the queue
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> ((push_word >> width_eff) == 9'd0));

    // R6: a stored character is visible on the next cycle
    p_avail_after_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> rx_avail);

    // R7: the head only changes on a read
    p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_avail && !rd_data && rx_en) |=>
            ($stable(data_out) && $stable(bit9_out) && $stable(fe_out) && $stable(pe_out)));

    // R9: a low enable empties the queue
    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_avail);

endmodule

bind serial_rx_fifo serial_rx_fifo_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .rd_data    (rd_data),
    .cfg_bits   (cfg_bits),
    .rx_avail   (rx_avail),
    .data_out   (data_out),
    .bit9_out   (bit9_out),
    .fe_out     (fe_out),
    .pe_out     (pe_out),
    .push_valid (smp_push),
    .push_word  (smp_word)
);

// File: tb/test_serial_rx_fifo.sv
`timescale 1ns/1ps
module test_serial_rx_fifo;

    localparam int BIT_CLKS = 64;   // 16 ticks, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [3:0] cfg_bits = 4'd8;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rd_data = 1'b0;
    logic [7:0] data_out;
    logic       bit9_out, fe_out, dor_out, pe_out, rx_avail;

    logic [1:0] tdiv = 2'd0;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  mon_en = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        logic [11:0] fields;   // {data, bit9, fe, dor, pe}
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tdiv    <= tdiv + 2'd1;
        os_tick <= (tdiv == 2'd3);
    end

    serial_rx_fifo i_serial_rx_fifo (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
        .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_data(rd_data), .data_out(data_out), .bit9_out(bit9_out), .fe_out(fe_out),
        .dor_out(dor_out), .pe_out(pe_out), .rx_avail(rx_avail)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [11:0] head_now();
        return {data_out, bit9_out, fe_out, dor_out, pe_out};
    endfunction

    task automatic line_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic idle_bits(input int n);
        rxd = 1'b1;
        repeat (n * BIT_CLKS) @(negedge clk);
    endtask

    // drives one frame and, when asked, pushes its expected entry
    task automatic send_frame(input logic [8:0] val, input logic [3:0] cfg, input bit pen,
                              input bit podd, input bit bad_par, input logic stop_v,
                              input bit expect_it, input string tag);
        int nb;
        logic [8:0] m;
        logic p;
        exp_t e;
        @(negedge clk);
        cfg_bits = cfg; cfg_par_en = pen; cfg_par_odd = podd;
        nb = (cfg < 4'd5) ? 5 : ((cfg > 4'd9) ? 9 : int'(cfg));
        m  = val & ((9'd1 << nb) - 9'd1);
        p  = (^m) ^ podd ^ bad_par;
        e.fields = {m[7:0], m[8], ~stop_v, 1'b0, bad_par & pen};
        e.tag = tag;
        if (expect_it) sb.push_back(e);
        line_bit(1'b0);
        for (int i = 0; i < nb; i++) line_bit(val[i]);
        if (pen) line_bit(p);
        line_bit(stop_v);
        rxd = 1'b1;
    endtask

    task automatic read_pulse();
        @(negedge clk) rd_data = 1'b1;
        @(negedge clk) rd_data = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (4 * BIT_CLKS) @(negedge clk);
        chk(sb.size() == 0, tag, "all expected characters delivered", sb.size(), 0);
    endtask

    // monitor: compares every delivered character against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && rx_avail) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R6", "unexpected character", head_now(), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(head_now() == e.fields, e.tag, "head {data,b9,fe,dor,pe}",
                        head_now(), e.fields);
                end
                rd_data = 1'b1;
                @(negedge clk);
                rd_data = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!rx_avail, "R6", "reset rx_avail", rx_avail, 0);
        chk(head_now() == 12'h0, "R6", "reset head fields", head_now(), 0);

        // pop on empty queue has no effect (R7)
        read_pulse();
        chk(!rx_avail, "R7", "pop on empty", rx_avail, 0);
        mon_en = 1'b1;
        idle_bits(2);

        // 8-bit characters, several patterns (R2)
        send_frame(9'h055, 4'd8, 0, 0, 0, 1'b1, 1, "R2");
        send_frame(9'h0A3, 4'd8, 0, 0, 0, 1'b1, 1, "R2");
        send_frame(9'h000, 4'd8, 0, 0, 0, 1'b1, 1, "R2");
        send_frame(9'h0FF, 4'd8, 0, 0, 0, 1'b1, 1, "R2");
        drain("R2");

        // narrow widths zero-masked, clamping of width (R3, R2)
        send_frame(9'h0B6, 4'd5, 0, 0, 0, 1'b1, 1, "R3");
        send_frame(9'h1FF, 4'd7, 0, 0, 0, 1'b1, 1, "R3");
        send_frame(9'h1FF, 4'd3, 0, 0, 0, 1'b1, 1, "R2");
        send_frame(9'h155, 4'd12, 0, 0, 0, 1'b1, 1, "R2");
        send_frame(9'h1A5, 4'd9, 0, 0, 0, 1'b1, 1, "R3");
        send_frame(9'h1A5, 4'd8, 0, 0, 0, 1'b1, 1, "R3");
        drain("R3");

        // parity good and bad, even and odd (R4)
        send_frame(9'h037, 4'd8, 1, 0, 0, 1'b1, 1, "R4");
        send_frame(9'h037, 4'd8, 1, 0, 1, 1'b1, 1, "R4");
        send_frame(9'h024, 4'd7, 1, 1, 0, 1'b1, 1, "R4");
        send_frame(9'h024, 4'd7, 1, 1, 1, 1'b1, 1, "R4");
        send_frame(9'h1C3, 4'd9, 1, 1, 1, 1'b1, 1, "R4");
        drain("R4");

        // framing error, then a clean character (R5)
        send_frame(9'h05A, 4'd8, 0, 0, 0, 1'b0, 1, "R5");
        idle_bits(2);
        send_frame(9'h0C9, 4'd8, 0, 0, 0, 1'b1, 1, "R5");
        drain("R5");

        // short low glitch is rejected (R1)
        @(negedge clk) rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        idle_bits(3);
        chk(sb.size() == 0 && !rx_avail, "R1", "glitch stored nothing", rx_avail, 0);
        send_frame(9'h081, 4'd8, 0, 0, 0, 1'b1, 1, "R1");
        drain("R1");

        // back-to-back after a single stop bit (R5)
        send_frame(9'h012, 4'd8, 1, 0, 0, 1'b1, 1, "R5");
        send_frame(9'h0ED, 4'd8, 1, 0, 0, 1'b1, 1, "R5");
        send_frame(9'h07E, 4'd8, 1, 0, 0, 1'b1, 1, "R5");
        drain("R5");

        // overrun into a full queue (R8)
        mon_en = 1'b0;
        idle_bits(1);
        send_frame(9'h011, 4'd8, 0, 0, 0, 1'b1, 0, "R8");
        send_frame(9'h022, 4'd8, 0, 0, 0, 1'b1, 0, "R8");
        send_frame(9'h033, 4'd8, 0, 0, 0, 1'b1, 0, "R8");
        idle_bits(1);
        chk(rx_avail, "R8", "avail with full queue", rx_avail, 1);
        chk(head_now() == {8'h11, 4'b0000}, "R8", "oldest kept clean", head_now(), {8'h11, 4'b0000});
        read_pulse();
        chk(head_now() == {8'h22, 4'b0010}, "R8", "newest marked overrun", head_now(), {8'h22, 4'b0010});
        read_pulse();
        chk(!rx_avail, "R8", "third character dropped", rx_avail, 0);

        // head held while unread (R7)
        send_frame(9'h05C, 4'd8, 0, 0, 0, 1'b1, 0, "R7");
        idle_bits(3);
        chk(head_now() == {8'h5C, 4'b0000}, "R7", "head held unread", head_now(), {8'h5C, 4'b0000});

        // disable flushes, nothing received while off (R9)
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk);
        chk(!rx_avail, "R9", "flush on disable", rx_avail, 0);
        send_frame(9'h0AA, 4'd8, 0, 0, 0, 1'b1, 0, "R9");
        chk(!rx_avail, "R9", "no reception while off", rx_avail, 0);
        @(negedge clk) rx_en = 1'b1;
        idle_bits(2);
        chk(!rx_avail, "R9", "nothing after re-enable", rx_avail, 0);
        mon_en = 1'b1;
        send_frame(9'h03C, 4'd8, 0, 0, 0, 1'b1, 1, "R9");
        drain("R9");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule